// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address by reading a two-level translation table held in memory. A requester presents an address together with a start pulse. The walker uses the table base from its base input, reads one word from the first level and decodes it. If that entry points to a second-level table, the walker reads that table as well. Three mapping granules are supported: 1 MiB sections, 64 KiB large pages and 4 KiB small pages.

The memory side is a plain read port that allows one outstanding read. The walker raises a request with a word address and holds it until the memory accepts it. It then waits for a response valid pulse that carries the data. The result is a single-cycle done pulse. With it come a fault flag, the physical address and a page-size code. A start that arrives while a walk is in progress is ignored.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `busy`=0, `done`=0, `mem_req`=0.
- R2: A start is accepted only while `busy`=0. The first read address is `{tbl_base[31:14], va[31:20], 2'b00}`. A start seen while busy has no effect on the walk in progress.
- R3: A first-level entry whose low two bits are 2 completes as a section. The result is `pa = {entry[31:20], va[19:0]}` with page-size code 2 and no second read.
- R4: A first-level entry whose low two bits are 1 causes a second read at `{entry[31:10], va[19:12], 2'b00}`.
- R5: A first-level entry whose low two bits are 0 or 3 completes with `fault`=1, `pa`=0 and no second read.
- R6: A second-level entry whose low two bits are 1 gives a large page: `pa = {entry[31:16], va[15:0]}` with size code 1.
- R7: A second-level entry with bit 1 set gives a small page: `pa = {entry[31:12], va[11:0]}` with size code 0.
- R8: A second-level entry whose low two bits are 0 completes with `fault`=1 and `pa`=0.
- R9: `mem_req` stays high with a stable address until `mem_gnt` is seen. At most one read is outstanding. `done` is a single-cycle pulse, and `busy` drops in the same cycle that `done` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Translation request pulse |
| va | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | First-level table base (16 KiB aligned) |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Read request to memory |
| mem_addr | output | 32 | Byte address of the word being read |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Translation fault |
| pa | output | 32 | Physical address |
| pg_size | output | 2 | 0 = 4 KiB, 1 = 64 KiB, 2 = 1 MiB |

## Verification
The assertions check the handshake rules on every cycle. A request stays raised with a steady address until it is granted. No request is raised while a response is pending. `done` lasts one cycle and never coincides with `busy`. A fault always carries a zero address, and the size code is never 3. The decoding of each entry kind, the read addresses and the joining of address fields can only be shown by the bench. It runs directed section, large-page, small-page and fault tables, plus random walks, against a behavioural memory with variable grant and response latency.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] va,
  input  logic [AW-1:0] tbl_base,
  output logic          busy,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          done,
  output logic          fault,
  output logic [AW-1:0] pa,
  output logic [1:0]    pg_size
);
  typedef enum logic [2:0] {S_IDLE, S_REQ1, S_WAIT1, S_REQ2, S_WAIT2} st_t;
  st_t st;
  logic [31:0] va_q;
  logic [31:0] base_q;
  logic [31:0] l2_base;
  logic [1:0] code;

  assign code    = mem_rdata[1:0];
  assign busy    = (st != S_IDLE);
  assign mem_req = (st == S_REQ1) || (st == S_REQ2);
  assign mem_addr = (st == S_REQ2) ? {l2_base[31:10], va_q[19:12], 2'b00}
                                   : {base_q[31:14], va_q[31:20], 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      va_q <= '0;
      base_q <= '0;
      l2_base <= '0;
      done <= 1'b0;
      fault <= 1'b0;
      pa <= '0;
      pg_size <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          va_q <= va;
          base_q <= tbl_base;
          st <= S_REQ1;
        end
        S_REQ1: if (mem_gnt) st <= S_WAIT1;
        S_WAIT1: if (mem_rvalid) begin
          if (code == 2'd1) begin
            l2_base <= mem_rdata;
            st <= S_REQ2;
          end else begin
            done <= 1'b1;
            st <= S_IDLE;
            if (code == 2'd2) begin
              fault <= 1'b0;
              pa <= {mem_rdata[31:20], va_q[19:0]};
              pg_size <= 2'd2;
            end else begin
              fault <= 1'b1;
              pa <= '0;
              pg_size <= 2'd0;
            end
          end
        end
        S_REQ2: if (mem_gnt) st <= S_WAIT2;
        S_WAIT2: if (mem_rvalid) begin
          done <= 1'b1;
          st <= S_IDLE;
          if (mem_rdata[1]) begin
            fault <= 1'b0;
            pa <= {mem_rdata[31:12], va_q[11:0]};
            pg_size <= 2'd0;
          end else if (mem_rdata[0]) begin
            fault <= 1'b0;
            pa <= {mem_rdata[31:16], va_q[15:0]};
            pg_size <= 2'd1;
          end else begin
            fault <= 1'b1;
            pa <= '0;
            pg_size <= 2'd0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_gnt,
  input logic        mem_rvalid,
  input logic        done,
  input logic        fault,
  input logic [31:0] pa,
  input logic [1:0]  pg_size
);
  logic pend;
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else if (mem_req && mem_gnt) pend <= 1'b1;
    else if (mem_rvalid) pend <= 1'b0;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !mem_req && !done); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) mem_req && !mem_gnt |=> mem_req && $stable(mem_addr)); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n) pend |-> !mem_req); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n) done && fault |-> pa == 32'd0); // R5
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) done |-> pg_size != 2'd3); // R3
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .done(done), .fault(fault),
  .pa(pa), .pg_size(pg_size)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] va = 0, tbl_base = 0;
  logic busy, mem_req, mem_gnt, mem_rvalid, done, fault;
  logic [31:0] mem_addr, mem_rdata, pa;
  logic [1:0] pg_size;
  int errs = 0, checks = 0, reads = 0;
  logic [31:0] l1_ent, l2_ent, last_addr1, last_addr2;

  always #5 clk = ~clk;

  pt_walker u_pt_walker (.*);

  // behavioural memory: answers only two addresses, random latency
  initial begin
    mem_gnt = 0; mem_rvalid = 0; mem_rdata = 0;
    forever begin
      @(negedge clk);
      mem_gnt = 0; mem_rvalid = 0;
      if (mem_req && ($urandom % 3 != 0)) begin
        mem_gnt = 1;
        if (reads == 0) last_addr1 = mem_addr; else last_addr2 = mem_addr;
        @(negedge clk);
        mem_gnt = 0;
        repeat ($urandom % 3) @(negedge clk);
        mem_rdata = (reads == 0) ? l1_ent : l2_ent;
        reads++;
        mem_rvalid = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin errs++; $display("FAIL %s act=%h exp=%h", r, act, exp); end
  endtask

  task automatic walk(input logic [31:0] v, input logic [31:0] b, input logic [31:0] e1, input logic [31:0] e2,
                      input bit poke);
    logic [31:0] epa; logic ef; logic [1:0] es; int en;
    l1_ent = e1; l2_ent = e2; reads = 0;
    en = 1; ef = 0; es = 0; epa = 0;
    case (e1[1:0])
      2'd2: begin epa = {e1[31:20], v[19:0]}; es = 2; end
      2'd1: begin
        en = 2;
        if (e2[1]) epa = {e2[31:12], v[11:0]};
        else if (e2[0]) begin epa = {e2[31:16], v[15:0]}; es = 1; end
        else ef = 1;
      end
      default: ef = 1;
    endcase
    @(negedge clk); va = v; tbl_base = b; start = 1;
    @(negedge clk); start = 0;
    if (poke) begin va = ~v; tbl_base = ~b; start = 1; @(negedge clk); start = 0; end
    while (!done) @(negedge clk);
    chk(fault == ef, ef ? "R5/R8 fault" : "R3/R6/R7 fault flag", fault, ef);
    chk(pa == epa, es == 2 ? "R3 pa" : (es == 1 ? "R6 pa" : "R7/R8 pa"), pa, epa);
    if (!ef) chk(pg_size == es, "R3/R6/R7 size", pg_size, es);
    chk(reads == en, "R4/R5 read count", reads, en);
    chk(last_addr1 == {b[31:14], v[31:20], 2'b00}, "R2 l1 addr", last_addr1, {b[31:14], v[31:20], 2'b00});
    if (en == 2)
      chk(last_addr2 == {e1[31:10], v[19:12], 2'b00}, "R4 l2 addr", last_addr2, {e1[31:10], v[19:12], 2'b00});
    @(negedge clk);
    chk(!done && !busy, "R9 done pulse", {done, busy}, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !done, "R1 reset", {busy, mem_req, done}, 0);
    rst_n = 1;
    walk(32'h1234_5678, 32'h8000_4000, 32'hABC0_0002, 0, 0);
    walk(32'hFFF0_0000, 32'h0000_C000, 32'h0000_0003, 0, 0);
    walk(32'h0000_0ABC, 32'h0000_0000, 32'h0000_0000, 0, 0);
    walk(32'h00A5_1234, 32'h1234_8000, 32'h4567_8C01, 32'hDEAD_0001, 0);
    walk(32'hC0FF_EEEE, 32'hFFFF_C000, 32'hFFFF_FC01, 32'h1357_9002, 0);
    walk(32'h4433_2211, 32'h0000_4000, 32'h0000_0401, 32'h2468_A003, 0);
    walk(32'h7777_7777, 32'h0000_8000, 32'h0000_0801, 32'h0000_0000, 0);
    walk(32'h0102_0304, 32'h8000_0000, 32'h9990_0002, 0, 1);
    walk(32'h0BAD_F00D, 32'h4000_4000, 32'h1111_1401, 32'h2222_2002, 1);
    for (int i = 0; i < 60; i++)
      walk($urandom, $urandom, $urandom, $urandom, i[0]);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #2000000;
    errs++; checks++;
    $display("FAIL watchdog");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule